// File: doc/BRIEF.md
# Multi-Mode Integer Multiplier

This block is the integer multiply unit of an execute stage. It takes two register-width operands, the three-bit function code of a multiply instruction, a word-mode flag and an extension-enable bit. It decodes the function code into a signedness flag for each operand and a select between the upper and lower half of the product. It forms the exact double-width product over several cycles and returns the selected register-width half.

Operands arrive on a valid/ready handshake. The result leaves on a second valid/ready handshake and is held until the consumer takes it. A request the unit cannot execute is answered at once with an illegal flag and a zero result. Such a request is one with the extension disabled, a function code outside the multiply group, or an unsupported word-mode combination. The multiplier retires `DIGIT_W` multiplier bits per cycle. A word-mode request finishes early because its operands carry only 32 significant bits.

Top module: `imul_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Function code 000 with `in_word`=0 returns bits [XLEN-1:0] of the product of the two operands.
- R3: Function code 001 returns bits [2*XLEN-1:XLEN] of the product with both operands taken as two's-complement signed.
- R4: Function code 010 returns the upper half of the product with operand 1 signed and operand 2 unsigned.
- R5: Function code 011 returns the upper half of the product with both operands unsigned.
- R6: With `in_word`=1 and function code 000 (legal only when XLEN is 64), only bits [31:0] of each operand are used. The result is bits [31:0] of their product, sign-extended from bit 31 to XLEN bits.
- R7: A request is illegal if `ext_enable` is 0, or if bit 2 of the function code is 1, or if `in_word` is 1 with a function code other than 000, or if `in_word` is 1 with XLEN other than 64. An illegal request returns `out_illegal`=1 and `out_result`=0. Its `out_valid` rises at the accepting clock edge itself. A legal request returns `out_illegal`=0.
- R8: For a legal request, `out_valid` rises at the XLEN/DIGIT_W-th clock edge after the accepting edge. In word mode it rises at the 32/DIGIT_W-th edge.
- R9: `in_ready` is 0 from acceptance until the result is taken. While `out_valid`=1 and `out_ready`=0, `out_result` and `out_illegal` hold. After the edge where `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to accept |
| in_funct3 | input | 3 | Function code selecting signedness and result half |
| in_word | input | 1 | Word-mode request |
| in_op1 | input | XLEN | Operand 1 |
| in_op2 | input | XLEN | Operand 2 |
| ext_enable | input | 1 | Multiply extension enabled |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | XLEN | Selected half of the product |
| out_illegal | output | 1 | Request was rejected as illegal |

## Verification
The bench builds the unit with XLEN=64 and DIGIT_W=8. That makes a full request eight cycles long and a word-mode request four cycles long. It also makes word mode legal, so the sign extension from bit 31 and the use of only the low 32 operand bits can be checked. It also gives the most-negative 64-bit operand, whose magnitude needs the full unsigned width. All-ones operands, mixed-signedness high products and the illegal codes are directed cases. Seeded random requests are mixed in between them.

// File: rtl/imul_pkg.sv
// Shared types for the multiply unit.
// Assumes: none beyond IEEE 1800-2017.
package imul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } imul_state_e;

    typedef struct packed {
        logic op1_signed;
        logic op2_signed;
        logic take_high;
        logic word;
    } imul_ctrl_t;

endpackage

// File: rtl/imul_decode.sv
// Maps the function code, word flag and extension enable to control flags.
// Assumes: only codes 000..011 belong to the multiply group; word mode is
// legal only with code 000 and a 64-bit register width.
module imul_decode
    import imul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2:0] funct3,
    input  logic       word,
    input  logic       ext_enable,
    output imul_ctrl_t ctrl,
    output logic       illegal
);

    localparam bit WORD_OK = (XLEN == 64);

    // Decode signedness and result half from the function code.
    always_comb begin
        ctrl = '0;
        ctrl.word = word;
        unique case (funct3[1:0])
            2'b00: ctrl.take_high = 1'b0;
            2'b01: begin
                ctrl.take_high  = 1'b1;
                ctrl.op1_signed = 1'b1;
                ctrl.op2_signed = 1'b1;
            end
            2'b10: begin
                ctrl.take_high  = 1'b1;
                ctrl.op1_signed = 1'b1;
            end
            default: ctrl.take_high = 1'b1;
        endcase
    end

    // Flag requests the unit cannot execute.
    always_comb begin
        illegal = !ext_enable || funct3[2];
        if (word && (!WORD_OK || funct3 != 3'b000)) illegal = 1'b1;
    end

endmodule

// File: rtl/imul_operand_prep.sv
// Trims operands in word mode and converts them to sign and magnitude.
// Assumes: the magnitude of the most negative value fits as unsigned XLEN bits.
module imul_operand_prep #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] op1,
    input  logic [XLEN-1:0] op2,
    input  logic            op1_signed,
    input  logic            op2_signed,
    input  logic            word,
    output logic [XLEN-1:0] mag1,
    output logic [XLEN-1:0] mag2,
    output logic            neg
);

    logic [XLEN-1:0] trim1, trim2;
    logic            neg1, neg2;

    generate
        if (XLEN > 32) begin : g_trim
            // Keep only the low 32 bits of each operand in word mode.
            always_comb begin
                trim1 = word ? {{(XLEN-32){1'b0}}, op1[31:0]} : op1;
                trim2 = word ? {{(XLEN-32){1'b0}}, op2[31:0]} : op2;
            end
        end else begin : g_pass
            // No narrower mode exists at this width.
            always_comb begin
                trim1 = op1;
                trim2 = op2;
            end
        end
    endgenerate

    // Form magnitudes and the sign of the final product.
    always_comb begin
        neg1 = op1_signed && trim1[XLEN-1];
        neg2 = op2_signed && trim2[XLEN-1];
        mag1 = neg1 ? (~trim1 + 1'b1) : trim1;
        mag2 = neg2 ? (~trim2 + 1'b1) : trim2;
        neg  = neg1 ^ neg2;
    end

endmodule

// File: rtl/imul_iter_core.sv
// Unsigned shift-and-add multiplier retiring DIGIT_W multiplier bits per step.
// Assumes: the caller issues exactly enough steps to consume the significant
// multiplier bits; the accumulator then holds the exact 2*XLEN product.
module imul_iter_core #(
    parameter int XLEN    = 64,
    parameter int DIGIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [XLEN-1:0]   mcand_in,
    input  logic [XLEN-1:0]   mplier_in,
    output logic [2*XLEN-1:0] acc
);

    localparam int PW = 2 * XLEN;

    logic [PW-1:0]      mcand_q, acc_q, partial;
    logic [XLEN-1:0]    mplier_q;
    logic [DIGIT_W-1:0] digit;
    logic [PW-1:0]      rows [DIGIT_W];

    assign digit = mplier_q[DIGIT_W-1:0];

    generate
        for (genvar j = 0; j < DIGIT_W; j++) begin : g_row
            assign rows[j] = digit[j] ? (mcand_q << j) : '0;
        end
    endgenerate

    // Sum the partial-product rows of the current digit.
    always_comb begin
        partial = '0;
        for (int j = 0; j < DIGIT_W; j++) partial = partial + rows[j];
    end

    // Load operands, then accumulate one digit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
        end else if (load) begin
            mcand_q  <= {{XLEN{1'b0}}, mcand_in};
            mplier_q <= mplier_in;
            acc_q    <= '0;
        end else if (step) begin
            acc_q    <= acc_q + partial;
            mcand_q  <= mcand_q << DIGIT_W;
            mplier_q <= mplier_q >> DIGIT_W;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/imul_result_fmt.sv
// Restores the product sign and selects the returned half.
// Assumes: acc is the exact unsigned product of the magnitudes.
module imul_result_fmt #(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0] acc,
    input  logic              neg,
    input  logic              take_high,
    input  logic              word,
    input  logic              illegal,
    output logic [XLEN-1:0]   result
);

    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0]   word_res;

    // Apply the sign of the product.
    always_comb prod = neg ? (~acc + 1'b1) : acc;

    generate
        if (XLEN > 32) begin : g_wext
            // Sign-extend the low 32 bits for word mode.
            always_comb word_res = {{(XLEN-32){prod[31]}}, prod[31:0]};
        end else begin : g_wnone
            // Word mode is rejected at this width.
            always_comb word_res = prod[XLEN-1:0];
        end
    endgenerate

    // Pick the half the request asked for.
    always_comb begin
        if (illegal)        result = '0;
        else if (word)      result = word_res;
        else if (take_high) result = prod[2*XLEN-1:XLEN];
        else                result = prod[XLEN-1:0];
    end

endmodule

// File: rtl/imul_unit.sv
// Multi-mode integer multiplier with request and result handshakes.
// Assumes: DIGIT_W divides 32 and XLEN; one request is in flight at a time.
module imul_unit
    import imul_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int DIGIT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [2:0]      in_funct3,
    input  logic            in_word,
    input  logic [XLEN-1:0] in_op1,
    input  logic [XLEN-1:0] in_op2,
    input  logic            ext_enable,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_result,
    output logic            out_illegal
);

    localparam int STEPS  = XLEN / DIGIT_W;
    localparam int WSTEPS = 32 / DIGIT_W;
    localparam int CNT_W  = $clog2(STEPS) + 1;

    imul_state_e       state_q;
    logic [CNT_W-1:0]  cnt_q;
    imul_ctrl_t        dec_ctrl, ctrl_q;
    logic              dec_illegal, illegal_q;
    logic              prep_neg, neg_q;
    logic [XLEN-1:0]   mag1, mag2;
    logic [2*XLEN-1:0] acc;
    logic              accept, last_step;

    imul_decode #(.XLEN(XLEN)) u_decode (
        .funct3     (in_funct3),
        .word       (in_word),
        .ext_enable (ext_enable),
        .ctrl       (dec_ctrl),
        .illegal    (dec_illegal)
    );

    imul_operand_prep #(.XLEN(XLEN)) u_prep (
        .op1        (in_op1),
        .op2        (in_op2),
        .op1_signed (dec_ctrl.op1_signed),
        .op2_signed (dec_ctrl.op2_signed),
        .word       (dec_ctrl.word),
        .mag1       (mag1),
        .mag2       (mag2),
        .neg        (prep_neg)
    );

    imul_iter_core #(.XLEN(XLEN), .DIGIT_W(DIGIT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && !dec_illegal),
        .step      (state_q == ST_BUSY),
        .mcand_in  (mag1),
        .mplier_in (mag2),
        .acc       (acc)
    );

    imul_result_fmt #(.XLEN(XLEN)) u_fmt (
        .acc       (acc),
        .neg       (neg_q),
        .take_high (ctrl_q.take_high),
        .word      (ctrl_q.word),
        .illegal   (illegal_q),
        .result    (out_result)
    );

    // Handshake and step-limit terms.
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_DONE);
        accept    = in_valid && in_ready;
        last_step = ctrl_q.word ? (cnt_q == CNT_W'(WSTEPS - 1))
                                : (cnt_q == CNT_W'(STEPS - 1));
    end

    // Sequence idle, iteration and result hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            ctrl_q    <= '0;
            neg_q     <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (in_valid) begin
                    ctrl_q    <= dec_ctrl;
                    neg_q     <= prep_neg;
                    illegal_q <= dec_illegal;
                    cnt_q     <= '0;
                    state_q   <= dec_illegal ? ST_DONE : ST_BUSY;
                end
                ST_BUSY: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_step) state_q <= ST_DONE;
                end
                ST_DONE: if (out_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign out_illegal = illegal_q;

endmodule

// File: rtl/imul_unit_chk.sv
// Protocol and timing checks for imul_unit, attached by bind.
// Assumes: the ports of imul_unit only; no internal signals are read.
module imul_unit_chk #(
    parameter int XLEN    = 64,
    parameter int DIGIT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            in_word,
    input logic            out_valid,
    input logic            out_ready,
    input logic [XLEN-1:0] out_result,
    input logic            out_illegal
);

    localparam logic [15:0] FULL_LAT = 16'(XLEN / DIGIT_W);
    localparam logic [15:0] WORD_LAT = 16'(32 / DIGIT_W);

    logic        word_q;
    logic [15:0] lat_q;

    // Track word mode and edges since the last acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= 1'b0;
            lat_q  <= '0;
        end else if (in_valid && in_ready) begin
            word_q <= in_word;
            lat_q  <= '0;
        end else if (!out_valid && lat_q != 16'hFFFF) begin
            lat_q  <= lat_q + 1'b1;
        end
    end

    assert_ready_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready));

    assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_result == '0));

    assert_word_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal && word_q) |->
        ((out_result[XLEN-1:31] == '0) || (out_result[XLEN-1:31] == '1)));

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |->
        (lat_q == (out_illegal ? 16'd0 : (word_q ? WORD_LAT : FULL_LAT))));

endmodule

bind imul_unit imul_unit_chk #(.XLEN(XLEN), .DIGIT_W(DIGIT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_word     (in_word),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/imul_unit_tb_top.sv
// Self-checking bench for imul_unit: directed corners plus seeded random.
module imul_unit_tb_top;

    localparam int XL = 64;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready, in_word, ext_enable;
    logic [2:0]    in_funct3;
    logic [XL-1:0] in_op1, in_op2, out_result;
    logic          out_valid, out_ready, out_illegal;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    imul_unit #(.XLEN(XL), .DIGIT_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_funct3(in_funct3), .in_word(in_word), .in_op1(in_op1), .in_op2(in_op2),
        .ext_enable(ext_enable), .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_illegal(out_illegal)
    );

    task automatic check(input bit ok, input string req, input logic [XL-1:0] act,
                         input logic [XL-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [XL-1:0] ref_result(input logic [2:0] f3, input logic w,
                                                 input logic [XL-1:0] a, input logic [XL-1:0] b);
        logic signed [2*XL+1:0] ea, eb, pr;
        logic [63:0] wp;
        if (w) begin
            wp = {32'b0, a[31:0]} * {32'b0, b[31:0]};
            return {{32{wp[31]}}, wp[31:0]};
        end
        ea = (f3 == 3'b001 || f3 == 3'b010) ? {{(XL+2){a[XL-1]}}, a} : {{(XL+2){1'b0}}, a};
        eb = (f3 == 3'b001) ? {{(XL+2){b[XL-1]}}, b} : {{(XL+2){1'b0}}, b};
        pr = ea * eb;
        return (f3 == 3'b000) ? pr[XL-1:0] : pr[2*XL-1:XL];
    endfunction

    function automatic string req_of(input logic [2:0] f3, input logic w, input logic ill);
        if (ill) return "R7";
        if (w) return "R6";
        case (f3)
            3'b000:  return "R2";
            3'b001:  return "R3";
            3'b010:  return "R4";
            default: return "R5";
        endcase
    endfunction

    // One request through both handshakes; called at a falling edge.
    task automatic run_op(input logic [2:0] f3, input logic w, input logic en,
                          input logic [XL-1:0] a, input logic [XL-1:0] b, input int hold);
        logic          exp_ill;
        logic [XL-1:0] exp_res, held;
        int            lat, exp_lat;
        string         rq;
        exp_ill = !en || f3[2] || (w && f3 != 3'b000);
        exp_res = exp_ill ? '0 : ref_result(f3, w, a, b);
        exp_lat = exp_ill ? 0 : (w ? 32 / DW : XL / DW);
        rq      = req_of(f3, w, exp_ill);
        in_valid = 1'b1; in_funct3 = f3; in_word = w; ext_enable = en;
        in_op1 = a; in_op2 = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R9 busy", {63'b0, in_ready}, '0);
        lat = 0;
        while (!out_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, "R8 latency", XL'(lat), XL'(exp_lat));
        check(out_illegal == exp_ill, {rq, " illegal flag"}, {63'b0, out_illegal}, {63'b0, exp_ill});
        check(out_result == exp_res, {rq, " result"}, out_result, exp_res);
        held = out_result;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(out_valid && out_result == held, "R9 hold", out_result, held);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && in_ready, "R9 release", {62'b0, out_valid, in_ready}, 64'd1);
    endtask

    function automatic logic [XL-1:0] pick_operand();
        case ($urandom_range(0, 7))
            0:       return {1'b1, {(XL-1){1'b0}}};
            1:       return '1;
            2:       return '0;
            3:       return {1'b0, {(XL-1){1'b1}}};
            4:       return {32'hDEAD_BEEF, 32'h8000_0000};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [XL-1:0] mn, ones;
        void'($urandom(32'd20240611));
        mn   = {1'b1, {(XL-1){1'b0}}};
        ones = '1;
        rst_n = 1'b0; in_valid = 1'b0; in_funct3 = '0; in_word = 1'b0;
        in_op1 = '0; in_op2 = '0; ext_enable = 1'b1; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset state",
              {62'b0, out_valid, in_ready}, 64'd1);

        // Directed corners.
        run_op(3'b000, 1'b0, 1'b1, 64'd7, 64'd6, 0);            // R2
        run_op(3'b000, 1'b0, 1'b1, ones, ones, 1);              // R2
        run_op(3'b001, 1'b0, 1'b1, mn, mn, 2);                  // R3
        run_op(3'b001, 1'b0, 1'b1, mn, ones, 0);                // R3
        run_op(3'b001, 1'b0, 1'b1, ones, ones, 0);              // R3
        run_op(3'b010, 1'b0, 1'b1, mn, ones, 0);                // R4
        run_op(3'b010, 1'b0, 1'b1, ones, ones, 3);              // R4
        run_op(3'b011, 1'b0, 1'b1, ones, ones, 0);              // R5
        run_op(3'b011, 1'b0, 1'b1, mn, mn, 0);                  // R5
        run_op(3'b000, 1'b1, 1'b1, {32'hFFFF_FFFF, 32'h8000_0000}, 64'd1, 0); // R6
        run_op(3'b000, 1'b1, 1'b1, {32'h1234_5678, 32'hFFFF_FFFF}, {32'hABCD_0000, 32'hFFFF_FFFF}, 1); // R6
        run_op(3'b000, 1'b1, 1'b1, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000, 0); // R6
        run_op(3'b001, 1'b0, 1'b0, ones, ones, 1);              // R7 disabled
        run_op(3'b100, 1'b0, 1'b1, 64'd5, 64'd3, 0);            // R7 divide code
        run_op(3'b001, 1'b1, 1'b1, 64'd5, 64'd3, 0);            // R7 word high
        run_op(3'b111, 1'b1, 1'b0, mn, mn, 0);                  // R7 combined

        // Seeded random mix.
        for (int k = 0; k < 400; k++) begin
            logic [2:0] f3;
            logic       w, en;
            f3 = ($urandom_range(0, 15) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
            w  = ($urandom_range(0, 3) == 0);
            if (w && $urandom_range(0, 7) != 0) f3 = 3'b000;
            en = ($urandom_range(0, 31) != 0);
            run_op(f3, w, en, pick_operand(), pick_operand(), $urandom_range(0, 2));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule